// File: doc/BRIEF.md
# Triggered Analog Multiplexer Readout Sequencer

This block drives the control lines of a 128-channel analog multiplexer that sits behind a bank of front-end sample-and-hold stages. A single event trigger starts a chain of three programmable delays, each counted in cycles of the fast system clock. The hold delay places the HOLD edge at the peak of the front-end signals, so that the sampled voltages freeze there. The readout delay sets the gap before the multiplexer is walked. The ADC delay starts at readout start and places a one-cycle trigger for the external digitizer.

The multiplexer walk runs at a slow step rate. A prescaler divides the system clock by `DIV` into ticks, and three ticks make one step. The walk has three parts. First comes one step of multiplexer reset. Next comes one step with the shift-in line high, during which the first multiplexer clock loads a single token bit. After that the clock advances the token. The first and last strips each dwell for three steps and every other strip for one, which gives 3 + 126 + 3 = 132 sample slots. HOLD is released when the last slot ends, and the block reports busy until both the walk and the ADC trigger are done. A trigger that arrives while the block is busy is dropped and counted.

Top module: `amux_readout_seq`

## Requirements
- R1: After reset, all control outputs are low, busy is low and the rejected-trigger count is zero.
- R2: A trigger sampled high while idle is accepted: busy rises at that edge and the three delay inputs are captured there. Later changes to the delay inputs have no effect on the run.
- R3: HOLD rises `hold_dly + 1` cycles after busy rises.
- R4: The multiplexer reset output rises `ro_dly + 1` cycles after HOLD rises and stays high for exactly one step (P = 3·DIV cycles).
- R5: Shift-in is high for exactly one step, beginning the cycle the multiplexer reset falls, and is low at all other times.
- R6: The walk emits exactly 128 multiplexer clock pulses, each DIV cycles wide and rising DIV cycles into its slot. Slots are numbered 0..131 after the reset step. The pulses fall in slot 0 and in slots 3..129, so that strip 0 and strip 127 each dwell three slots.
- R7: HOLD falls 133·P cycles after the multiplexer reset rises, at the end of slot 131.
- R8: Each accepted trigger yields exactly one ADC trigger pulse, one cycle wide, rising `adc_dly + 1` cycles after the multiplexer reset rises.
- R9: Busy falls at the later of the HOLD fall and the ADC trigger rise.
- R10: A trigger sampled high while busy does not alter the run in progress. Each such cycle adds one to the rejected-trigger count, which saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (delay resolution) |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Event trigger, sampled each cycle |
| hold_dly_i | input | DLY_W | Trigger-to-HOLD delay in cycles |
| ro_dly_i | input | DLY_W | HOLD-to-readout-start delay in cycles |
| adc_dly_i | input | DLY_W | Readout-start-to-ADC-trigger delay in cycles |
| hold_o | output | 1 | Freeze front-end samples |
| mux_clk_o | output | 1 | Multiplexer step clock |
| shin_o | output | 1 | Multiplexer token shift-in |
| mux_rst_o | output | 1 | Multiplexer shift register clear |
| adc_trig_o | output | 1 | One-cycle digitizer trigger |
| busy_o | output | 1 | Sequence in progress |
| rej_cnt_o | output | REJ_W | Saturating count of rejected trigger cycles |

## Verification
The bench mixes directed runs with random delay triples. The directed runs use all-zero delays, an ADC delay whose pulse lands on the same edge as the HOLD release, and an ADC delay that outlasts the walk. Together these separate which of the two ends releases busy. In every run the delay inputs are scrambled right after the trigger is accepted, and any dependence on live inputs instead of captured ones shows up as a timing error. Some runs add triggers in the middle of the run, lasting one cycle or many. These show that the run timing is untouched and that the count saturates. The 128 clock-pulse timestamps of each walk are compared with a slot map computed in the bench, which catches a stretched edge strip that is missing or misplaced.

// File: rtl/amux_seq_pkg.sv
package amux_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HWAIT = 2'd1,
    ST_RWAIT = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

  // Number of sample slots after the reset step.
  function automatic int unsigned slot_total(input int unsigned strips,
                                             input int unsigned edge_slots);
    return strips - 2 + 2 * edge_slots;
  endfunction

  // True when a multiplexer clock pulse belongs to the given slot.
  function automatic logic slot_has_clock(input int unsigned slot,
                                          input int unsigned strips,
                                          input int unsigned edge_slots);
    return (slot == 0) ||
           ((slot >= edge_slots) && (slot <= edge_slots + strips - 2));
  endfunction

endpackage

// File: rtl/amux_prescaler.sv
module amux_prescaler #(
  parameter int DIV        = 10,
  parameter int STEP_TICKS = 3,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int PW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [PW-1:0] phase,
  output logic          step_end
);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = (cnt == CW'(DIV - 1));
  assign step_end = tick && (phase == PW'(STEP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= '0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= (phase == PW'(STEP_TICKS - 1)) ? '0 : phase + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PW'(STEP_TICKS - 1));

  p_tick_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (cnt == '0));

endmodule

// File: rtl/amux_delay.sv
module amux_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         done
);

  logic         run;
  logic [W-1:0] cnt;

  assign done = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= value;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !done);

endmodule

// File: rtl/amux_stepper.sv
module amux_stepper
  import amux_seq_pkg::*;
#(
  parameter int N_STRIPS   = 128,
  parameter int EDGE_SLOTS = 3,
  parameter int STEP_TICKS = 3,
  localparam int SLOTS = N_STRIPS - 2 + 2 * EDGE_SLOTS,
  localparam int SW    = $clog2(SLOTS),
  localparam int PW    = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step_end,
  input  logic [PW-1:0] phase,
  output logic          mux_rst,
  output logic          mux_clk,
  output logic          shin,
  output logic          last
);

  logic          active;
  logic          in_rst;
  logic [SW-1:0] slot;
  logic          walking;
  logic          clk_slot;

  assign walking  = active && !in_rst;
  assign clk_slot = slot_has_clock(32'(slot), N_STRIPS, EDGE_SLOTS);
  assign mux_rst  = active && in_rst;
  assign shin     = walking && (slot == '0);
  assign mux_clk  = walking && clk_slot && (phase == PW'(STEP_TICKS / 2));
  assign last     = walking && step_end && (slot == SW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      in_rst <= 1'b0;
      slot   <= '0;
    end else if (start) begin
      active <= 1'b1;
      in_rst <= 1'b1;
      slot   <= '0;
    end else if (active && step_end) begin
      if (in_rst)                        in_rst <= 1'b0;
      else if (slot == SW'(SLOTS - 1))   active <= 1'b0;
      else                               slot   <= slot + 1'b1;
    end
  end

  p_slot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SW'(SLOTS - 1));

  p_rst_then_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_rst && step_end && !start) |=> shin);

  p_no_clk_in_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mux_rst |-> (!mux_clk && !shin));

endmodule

// File: rtl/amux_readout_seq.sv
module amux_readout_seq
  import amux_seq_pkg::*;
#(
  parameter int DLY_W      = 16,
  parameter int DIV        = 10,
  parameter int STEP_TICKS = 3,
  parameter int N_STRIPS   = 128,
  parameter int EDGE_SLOTS = 3,
  parameter int REJ_W      = 16,
  localparam int PW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] hold_dly_i,
  input  logic [DLY_W-1:0] ro_dly_i,
  input  logic [DLY_W-1:0] adc_dly_i,
  output logic             hold_o,
  output logic             mux_clk_o,
  output logic             shin_o,
  output logic             mux_rst_o,
  output logic             adc_trig_o,
  output logic             busy_o,
  output logic [REJ_W-1:0] rej_cnt_o
);

  seq_state_e       state;
  logic [DLY_W-1:0] ro_q, adc_q;
  logic             accept, reject;
  logic             hd_done, ro_done, adc_done;
  logic             ro_start;
  logic             st_last;
  logic             step_end;
  logic [PW-1:0]    phase;
  logic             rd_fin, adc_fired;
  logic             walk_over, adc_over;

  assign busy_o    = (state != ST_IDLE);
  assign accept    = trig_i && (state == ST_IDLE);
  assign reject    = trig_i && (state != ST_IDLE);
  assign ro_start  = ro_done && (state == ST_RWAIT);
  assign walk_over = rd_fin || st_last;
  assign adc_over  = adc_fired || adc_done;

  amux_delay #(.W(DLY_W)) u_hold_dly (
    .clk(clk), .rst_n(rst_n), .load(accept), .value(hold_dly_i), .done(hd_done));

  amux_delay #(.W(DLY_W)) u_ro_dly (
    .clk(clk), .rst_n(rst_n), .load(hd_done && (state == ST_HWAIT)),
    .value(ro_q), .done(ro_done));

  amux_delay #(.W(DLY_W)) u_adc_dly (
    .clk(clk), .rst_n(rst_n), .load(ro_start), .value(adc_q), .done(adc_done));

  amux_prescaler #(.DIV(DIV), .STEP_TICKS(STEP_TICKS)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(ro_start), .phase(phase), .step_end(step_end));

  amux_stepper #(.N_STRIPS(N_STRIPS), .EDGE_SLOTS(EDGE_SLOTS), .STEP_TICKS(STEP_TICKS)) u_step (
    .clk(clk), .rst_n(rst_n), .start(ro_start), .step_end(step_end), .phase(phase),
    .mux_rst(mux_rst_o), .mux_clk(mux_clk_o), .shin(shin_o), .last(st_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ro_q       <= '0;
      adc_q      <= '0;
      hold_o     <= 1'b0;
      rd_fin     <= 1'b0;
      adc_fired  <= 1'b0;
      adc_trig_o <= 1'b0;
    end else begin
      adc_trig_o <= adc_done;
      case (state)
        ST_IDLE: if (accept) begin
          ro_q  <= ro_dly_i;
          adc_q <= adc_dly_i;
          state <= ST_HWAIT;
        end
        ST_HWAIT: if (hd_done) begin
          hold_o <= 1'b1;
          state  <= ST_RWAIT;
        end
        ST_RWAIT: if (ro_done) begin
          rd_fin    <= 1'b0;
          adc_fired <= 1'b0;
          state     <= ST_RUN;
        end
        default: begin
          if (st_last)  begin hold_o <= 1'b0; rd_fin <= 1'b1; end
          if (adc_done) adc_fired <= 1'b1;
          if (walk_over && adc_over) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             rej_cnt_o <= '0;
    else if (reject && (rej_cnt_o != '1))   rej_cnt_o <= rej_cnt_o + 1'b1;
  end

  p_hold_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> busy_o);

  p_clk_under_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mux_clk_o |-> hold_o);

  p_token_under_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shin_o |-> (hold_o && !mux_rst_o));

  p_rst_under_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mux_rst_o |-> hold_o);

  p_adc_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |=> !adc_trig_o);

  p_reject_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o && (rej_cnt_o != '1)) |=> (rej_cnt_o == $past(rej_cnt_o) + 1'b1));

  p_reject_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_cnt_o == '1) |=> (rej_cnt_o == '1));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!hold_o && !mux_clk_o && !shin_o && !mux_rst_o));

endmodule

// File: tb/sim_amux_readout_seq.sv
`timescale 1ns/1ps
module sim_amux_readout_seq;

  localparam int DIV   = 10;
  localparam int P     = 3 * DIV;
  localparam int NSTR  = 128;
  localparam int EDGE  = 3;
  localparam int REJW  = 6;
  localparam int REJMX = (1 << REJW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [15:0] hold_dly = '0, ro_dly = '0, adc_dly = '0;
  logic hold_o, mux_clk_o, shin_o, mux_rst_o, adc_trig_o, busy_o;
  logic [REJW-1:0] rej_cnt_o;

  always #2.5 clk = ~clk;

  amux_readout_seq #(.DIV(DIV), .N_STRIPS(NSTR), .EDGE_SLOTS(EDGE), .REJ_W(REJW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig),
    .hold_dly_i(hold_dly), .ro_dly_i(ro_dly), .adc_dly_i(adc_dly),
    .hold_o(hold_o), .mux_clk_o(mux_clk_o), .shin_o(shin_o), .mux_rst_o(mux_rst_o),
    .adc_trig_o(adc_trig_o), .busy_o(busy_o), .rej_cnt_o(rej_cnt_o));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int run_id = 0, seen_id = 0;
  int exp_rej = 0;

  int t_bu_r, t_bu_f, t_ho_r, t_ho_f, t_rs_r, t_rs_f, t_sh_r, t_sh_f, t_ad_r, t_ad_f;
  int n_sh, n_ad, n_ck;
  int ck_r [0:255];
  int ck_f [0:255];
  logic pb, ph, pr, ps, pa, pc;

  always @(posedge clk) cyc <= cyc + 1;

  // Event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (run_id != seen_id) begin
      seen_id = run_id;
      t_bu_r = -1; t_bu_f = -1; t_ho_r = -1; t_ho_f = -1; t_rs_r = -1; t_rs_f = -1;
      t_sh_r = -1; t_sh_f = -1; t_ad_r = -1; t_ad_f = -1;
      n_sh = 0; n_ad = 0; n_ck = 0;
    end
    if (busy_o && !pb) t_bu_r = cyc;
    if (!busy_o && pb) t_bu_f = cyc;
    if (hold_o && !ph) t_ho_r = cyc;
    if (!hold_o && ph) t_ho_f = cyc;
    if (mux_rst_o && !pr) t_rs_r = cyc;
    if (!mux_rst_o && pr) t_rs_f = cyc;
    if (shin_o && !ps) begin t_sh_r = cyc; n_sh++; end
    if (!shin_o && ps) t_sh_f = cyc;
    if (adc_trig_o && !pa) begin t_ad_r = cyc; n_ad++; end
    if (!adc_trig_o && pa) t_ad_f = cyc;
    if (mux_clk_o && !pc) begin if (n_ck < 256) ck_r[n_ck] = cyc; end
    if (!mux_clk_o && pc) begin if (n_ck < 256) ck_f[n_ck] = cyc; n_ck++; end
    pb = busy_o; ph = hold_o; pr = mux_rst_o; ps = shin_o; pa = adc_trig_o; pc = mux_clk_o;
  end

  function automatic int pulse_slot(input int k);
    return (k == 0) ? 0 : EDGE + k - 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_once(input int h, input int r, input int a, input int inj);
    int errs;
    run_id++;
    @(negedge clk);
    hold_dly = 16'(h); ro_dly = 16'(r); adc_dly = 16'(a);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    // R2: scramble the inputs after acceptance
    hold_dly = 16'($urandom); ro_dly = 16'($urandom); adc_dly = 16'($urandom);
    if (inj > 0) begin
      repeat ($urandom_range(40, 1500)) @(negedge clk);
      trig = 1'b1;
      repeat (inj) @(negedge clk);
      trig = 1'b0;
      exp_rej = (exp_rej + inj > REJMX) ? REJMX : exp_rej + inj;
    end
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);

    check(t_ho_r - t_bu_r == h + 1, "R3 hold delay", t_ho_r - t_bu_r, h + 1);
    check(t_rs_r - t_ho_r == r + 1, "R4 readout delay", t_rs_r - t_ho_r, r + 1);
    check(t_rs_f - t_rs_r == P, "R4 reset width", t_rs_f - t_rs_r, P);
    check(t_sh_r == t_rs_f, "R5 token start", t_sh_r, t_rs_f);
    check(t_sh_f - t_sh_r == P && n_sh == 1, "R5 token width", t_sh_f - t_sh_r, P);
    check(n_ck == NSTR, "R6 clock pulse count", n_ck, NSTR);
    errs = 0;
    for (int k = 0; k < NSTR; k++) begin
      if (ck_r[k] != t_rs_r + P * (pulse_slot(k) + 1) + DIV) errs++;
      if (ck_f[k] - ck_r[k] != DIV) errs++;
    end
    check(errs == 0, "R6 clock pulse timing errors", errs, 0);
    check(t_ho_f - t_rs_r == 133 * P, "R7 hold release", t_ho_f - t_rs_r, 133 * P);
    check(n_ad == 1, "R8 adc pulse count", n_ad, 1);
    check(t_ad_r - t_rs_r == a + 1, "R8 adc delay", t_ad_r - t_rs_r, a + 1);
    check(t_ad_f - t_ad_r == 1, "R8 adc width", t_ad_f - t_ad_r, 1);
    check(t_bu_f == max2(t_ho_f, t_ad_r), "R9 busy end", t_bu_f, max2(t_ho_f, t_ad_r));
    check(int'(rej_cnt_o) == exp_rej, "R10 rejected count", int'(rej_cnt_o), exp_rej);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({hold_o, mux_clk_o, shin_o, mux_rst_o, adc_trig_o, busy_o} == 6'b0,
          "R1 outputs after reset", int'({hold_o, mux_clk_o, shin_o, mux_rst_o, adc_trig_o, busy_o}), 0);
    check(rej_cnt_o == '0, "R1 rejected count after reset", int'(rej_cnt_o), 0);

    run_once(0, 0, 0, 0);                  // shortest delays
    run_once(7, 3, 133 * P - 1, 1);        // adc pulse on hold release edge
    run_once(20, 11, 4600, 0);             // adc outlasts the walk
    run_once(150, 90, 500, 100);           // long reject burst saturates R10
    for (int i = 0; i < 6; i++)
      run_once($urandom_range(0, 300), $urandom_range(0, 300),
               $urandom_range(0, 4200), (i % 2 == 0) ? 1 : 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule